// File: doc/BRIEF.md
# Dual-Channel Bus-Master Request Arbiter

This block decides when a two-channel DMA bus master asks for the system bus, and for which channel. The read channel moves data from the bus into an inbound FIFO, so it needs vacant inbound words. The write channel moves data from an outbound FIFO onto the bus, so it needs valid outbound words. Each channel has an enable, a remaining transfer count and a threshold-mode input. Two priority inputs choose read-first, write-first or equal alternation when both channels can run.

While the bus is not yet owned, a channel in four-word threshold mode waits until four words can move. Once the master owns the bus, a single word is enough for either channel. A channel that is serving the bus keeps it until it signals completion or loses eligibility. At that point the arbiter either hands the bus to the other channel or releases the request. The block also decodes eight status flags from the FIFO fill levels and the transfer counts.

The controller has three states. **IDLE** drives no request. **REQ** requests the bus and waits for a grant. **OWN** holds the bus and serves a channel. The transitions are:
- IDLE→REQ (`go_req`): some channel is eligible under its threshold.
- REQ→OWN (`granted`): grant is seen while some channel is eligible.
- REQ→IDLE (`abandon`): no channel is eligible.
- OWN→OWN (`continue`/`handover`): some channel is still eligible, with the threshold waived.
- OWN→IDLE (`release`): no channel is eligible.

Top module: `bm_req_arb`

## Requirements
- R1: After reset, `bus_req` is 0, `sel_wr` is 0 (read channel) and the alternation pointer favours the read channel.
- R2: A channel is never eligible unless its enable input is 1 and its transfer count is nonzero. With no eligible channel, `bus_req` is 0 in the following cycle.
- R3: While the bus is not owned and `rd_thr4` is 1, the read channel is eligible only with at least 4 vacant inbound words (DEPTH − `in_fill` ≥ 4). With `rd_thr4` at 0, one vacant word suffices.
- R4: While the bus is not owned and `wr_thr4` is 1, the write channel is eligible only with at least 4 valid outbound words (`out_fill` ≥ 4). With `wr_thr4` at 0, one valid word suffices.
- R5: In state OWN, both threshold inputs have no effect: either channel is eligible with one vacant or valid word.
- R6: With `rd_pri`=1 and `wr_pri`=0, read (`sel_wr`=0) is chosen whenever both channels are eligible at a selection point.
- R7: With `wr_pri`=1 and `rd_pri`=0, write (`sel_wr`=1) is chosen whenever both channels are eligible at a selection point.
- R8: With both priority inputs equal (both 1 or both 0), selection alternates. A `xfer_done` pulse in OWN while both channels are eligible moves the pointer to the channel that was not served. The pointer does not move when only one channel is eligible.
- R9: `bus_req` rises one cycle after a channel becomes eligible in IDLE. It falls one cycle after neither channel is eligible, from REQ or OWN, for example after a count reaches zero.
- R10: In REQ, `bus_gnt` moves the block to OWN. In OWN without `xfer_done`, the selected channel is kept while it stays eligible. Clearing its enable or exhausting its count suspends it and hands the bus to the other channel if that channel is eligible.
- R11: `stat` bits are [0] read count zero, [1] write count zero, [2] inbound empty, [3] inbound full, [4] inbound has ≥4 vacant words, [5] outbound empty, [6] outbound full, [7] outbound has ≥4 valid words. All are combinational from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read channel enable |
| wr_en | input | 1 | Write channel enable |
| rd_thr4 | input | 1 | Read channel four-vacant-word threshold mode |
| wr_thr4 | input | 1 | Write channel four-valid-word threshold mode |
| rd_pri | input | 1 | Read priority bit |
| wr_pri | input | 1 | Write priority bit |
| in_fill | input | $clog2(DEPTH+1) | Valid words in the inbound FIFO |
| out_fill | input | $clog2(DEPTH+1) | Valid words in the outbound FIFO |
| rd_count | input | CNT_W | Remaining read transfer count |
| wr_count | input | CNT_W | Remaining write transfer count |
| bus_gnt | input | 1 | Bus grant |
| xfer_done | input | 1 | The selected channel's granted transfer has completed |
| bus_req | output | 1 | Bus request |
| sel_wr | output | 1 | Selected channel: 0 read, 1 write |
| stat | output | 8 | Status flags (see R11) |

## Verification
On every cycle, the assertions check the following:
- A disabled or exhausted channel pair never leaves the request standing (R2).
- The read threshold holds off requests from IDLE (R3).
- Fixed priority picks the right channel out of IDLE (R6, R7).
- An owned channel that is still eligible keeps the bus (R10).
- Status flags that contradict each other never appear together (R11).

Some behaviours only show up over scripted sequences, and the bench's cycle model covers them:
- The threshold waiver after a grant (R5).
- The pointer moving only when both channels compete (R8).
- The exact cycle in which the request falls after suspension or count exhaustion (R9).

// File: rtl/bm_arb_pkg.sv
package bm_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_OWN  = 2'd2
    } arb_state_e;

    typedef enum logic {
        CH_RD = 1'b0,
        CH_WR = 1'b1
    } chan_e;

    localparam int THR_WORDS = 4;
    localparam int NUM_CH    = 2;
endpackage

// File: rtl/bm_chan_elig.sv
module bm_chan_elig
    import bm_arb_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FILL_W = 4
) (
    input  logic              en,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [FILL_W-1:0] avail,
    input  logic              thr4,
    output logic              elig_new,
    output logic              elig_own
);
    logic live;
    logic has_one;
    logic has_four;

    always_comb begin
        live     = en && (cnt != '0);
        has_one  = (avail != '0);
        has_four = (avail >= FILL_W'(THR_WORDS));
        elig_own = live && has_one;
        elig_new = live && (thr4 ? has_four : has_one);
    end
endmodule

// File: rtl/bm_arb_pick.sv
module bm_arb_pick
    import bm_arb_pkg::*;
(
    input  logic  e_rd,
    input  logic  e_wr,
    input  logic  rd_pri,
    input  logic  wr_pri,
    input  chan_e favour,
    output chan_e pick
);
    always_comb begin
        if (e_rd && !e_wr)             pick = CH_RD;
        else if (e_wr && !e_rd)        pick = CH_WR;
        else if (rd_pri && !wr_pri)    pick = CH_RD;
        else if (wr_pri && !rd_pri)    pick = CH_WR;
        else                           pick = favour;
    end
endmodule

// File: rtl/bm_arb_status.sv
module bm_arb_status #(
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 16,
    parameter int FILL_W = 4
) (
    input  logic [FILL_W-1:0] in_fill,
    input  logic [FILL_W-1:0] out_fill,
    input  logic [CNT_W-1:0]  rd_count,
    input  logic [CNT_W-1:0]  wr_count,
    output logic [7:0]        stat
);
    localparam logic [FILL_W-1:0] FULL_LVL = FILL_W'(DEPTH);
    localparam logic [FILL_W-1:0] FOUR     = FILL_W'(4);

    logic [FILL_W-1:0] in_vac;

    always_comb begin
        in_vac  = FULL_LVL - in_fill;
        stat[0] = (rd_count == '0);
        stat[1] = (wr_count == '0);
        stat[2] = (in_fill == '0);
        stat[3] = (in_fill == FULL_LVL);
        stat[4] = (in_vac >= FOUR);
        stat[5] = (out_fill == '0);
        stat[6] = (out_fill == FULL_LVL);
        stat[7] = (out_fill >= FOUR);
    end
endmodule

// File: rtl/bm_req_arb.sv
module bm_req_arb
    import bm_arb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 16,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              rd_thr4,
    input  logic              wr_thr4,
    input  logic              rd_pri,
    input  logic              wr_pri,
    input  logic [FILL_W-1:0] in_fill,
    input  logic [FILL_W-1:0] out_fill,
    input  logic [CNT_W-1:0]  rd_count,
    input  logic [CNT_W-1:0]  wr_count,
    input  logic              bus_gnt,
    input  logic              xfer_done,
    output logic              bus_req,
    output logic              sel_wr,
    output logic [7:0]        stat
);
    arb_state_e state_q, state_d;
    chan_e      sel_q, sel_d;
    chan_e      ptr_q, ptr_d;
    chan_e      pick;

    logic [FILL_W-1:0] avail_a [NUM_CH];
    logic              en_a    [NUM_CH];
    logic              thr_a   [NUM_CH];
    logic [CNT_W-1:0]  cnt_a   [NUM_CH];
    logic              elig_new [NUM_CH];
    logic              elig_own [NUM_CH];

    logic own, e_rd, e_wr, any_e, both_e, sel_still;
    chan_e favour;

    always_comb begin
        avail_a[0] = FILL_W'(DEPTH) - in_fill;
        avail_a[1] = out_fill;
        en_a[0]    = rd_en;
        en_a[1]    = wr_en;
        thr_a[0]   = rd_thr4;
        thr_a[1]   = wr_thr4;
        cnt_a[0]   = rd_count;
        cnt_a[1]   = wr_count;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        bm_chan_elig #(.CNT_W(CNT_W), .FILL_W(FILL_W)) u_elig (
            .en       (en_a[g]),
            .cnt      (cnt_a[g]),
            .avail    (avail_a[g]),
            .thr4     (thr_a[g]),
            .elig_new (elig_new[g]),
            .elig_own (elig_own[g])
        );
    end

    always_comb begin
        own       = (state_q == ST_OWN);
        e_rd      = own ? elig_own[0] : elig_new[0];
        e_wr      = own ? elig_own[1] : elig_new[1];
        any_e     = e_rd || e_wr;
        both_e    = e_rd && e_wr;
        sel_still = (sel_q == CH_WR) ? e_wr : e_rd;
        favour    = (own && xfer_done && both_e) ?
                    ((sel_q == CH_WR) ? CH_RD : CH_WR) : ptr_q;
    end

    bm_arb_pick u_pick (
        .e_rd   (e_rd),
        .e_wr   (e_wr),
        .rd_pri (rd_pri),
        .wr_pri (wr_pri),
        .favour (favour),
        .pick   (pick)
    );

    bm_arb_status #(.DEPTH(DEPTH), .CNT_W(CNT_W), .FILL_W(FILL_W)) u_stat (
        .in_fill  (in_fill),
        .out_fill (out_fill),
        .rd_count (rd_count),
        .wr_count (wr_count),
        .stat     (stat)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        ptr_d   = favour;
        unique case (state_q)
            ST_IDLE: begin
                if (any_e) begin
                    state_d = ST_REQ;
                    sel_d   = pick;
                end
            end
            ST_REQ: begin
                if (!any_e) begin
                    state_d = ST_IDLE;
                end else begin
                    if (bus_gnt) state_d = ST_OWN;
                    sel_d = pick;
                end
            end
            ST_OWN: begin
                if (!any_e)                      state_d = ST_IDLE;
                else if (xfer_done || !sel_still) sel_d = pick;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= CH_RD;
            ptr_q   <= CH_RD;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            ptr_q   <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        bus_req = (state_q != ST_IDLE);
        sel_wr  = (sel_q == CH_WR);
    end
endmodule

// File: rtl/bm_req_arb_chk.sv
module bm_req_arb_chk
    import bm_arb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 16,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic              rd_thr4,
    input logic              rd_pri,
    input logic              wr_pri,
    input logic [FILL_W-1:0] in_fill,
    input logic [FILL_W-1:0] out_fill,
    input logic [CNT_W-1:0]  rd_count,
    input logic [CNT_W-1:0]  wr_count,
    input logic              xfer_done,
    input logic              bus_req,
    input logic              sel_wr,
    input logic [7:0]        stat,
    input arb_state_e        state_q,
    input logic              rd_new,
    input logic              wr_new
);
    int vac;
    always_comb vac = DEPTH - int'(in_fill);

    AST_NO_ENABLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> !bus_req); // R2

    AST_ZERO_COUNT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_count == '0 && wr_count == '0) |=> !bus_req); // R2

    AST_RD_THRESHOLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rd_thr4 && vac < 4 && (!wr_en || wr_count == '0))
        |=> !bus_req); // R3

    AST_RD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rd_pri && !wr_pri && rd_new && wr_new)
        |=> (bus_req && !sel_wr)); // R6

    AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr_pri && !rd_pri && rd_new && wr_new)
        |=> (bus_req && sel_wr)); // R7

    AST_OWN_KEEPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWN && !xfer_done && !sel_wr && rd_en && rd_count != '0 && vac >= 1)
        |=> (bus_req && !sel_wr)); // R10

    AST_OWN_KEEPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWN && !xfer_done && sel_wr && wr_en && wr_count != '0 && out_fill != '0)
        |=> (bus_req && sel_wr)); // R10

    AST_STATUS_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat[2] && stat[3]) && !(stat[5] && stat[6]) && !(stat[3] && stat[4])); // R11
endmodule

bind bm_req_arb bm_req_arb_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rd_thr4   (rd_thr4),
    .rd_pri    (rd_pri),
    .wr_pri    (wr_pri),
    .in_fill   (in_fill),
    .out_fill  (out_fill),
    .rd_count  (rd_count),
    .wr_count  (wr_count),
    .xfer_done (xfer_done),
    .bus_req   (bus_req),
    .sel_wr    (sel_wr),
    .stat      (stat),
    .state_q   (state_q),
    .rd_new    (elig_new[0]),
    .wr_new    (elig_new[1])
);

// File: tb/bm_req_arb_tb.sv
module bm_req_arb_tb;
    localparam int DEPTH  = 8;
    localparam int CNT_W  = 16;
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 0, wr_en = 0, rd_thr4 = 0, wr_thr4 = 0, rd_pri = 0, wr_pri = 0;
    logic [FILL_W-1:0] in_fill = '0, out_fill = '0;
    logic [CNT_W-1:0]  rd_count = '0, wr_count = '0;
    logic bus_gnt = 0, xfer_done = 0;
    logic bus_req, sel_wr;
    logic [7:0] stat;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    // behavioural model: 0 idle, 1 requesting, 2 owning
    int m_st = 0;
    int m_sel = 0;
    int m_ptr = 0;

    always #10 clk = ~clk;

    bm_req_arb #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .rd_thr4(rd_thr4), .wr_thr4(wr_thr4), .rd_pri(rd_pri), .wr_pri(wr_pri),
        .in_fill(in_fill), .out_fill(out_fill), .rd_count(rd_count), .wr_count(wr_count),
        .bus_gnt(bus_gnt), .xfer_done(xfer_done),
        .bus_req(bus_req), .sel_wr(sel_wr), .stat(stat)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_sel = 0; m_ptr = 0;
        end else begin
            int vac, need_r, need_w, choice, pfav;
            bit er, ew, owning, keep;
            owning = (m_st == 2);
            vac    = DEPTH - int'(in_fill);
            need_r = (rd_thr4 && !owning) ? 4 : 1;
            need_w = (wr_thr4 && !owning) ? 4 : 1;
            er = rd_en && (rd_count != 0) && (vac >= need_r);
            ew = wr_en && (wr_count != 0) && (int'(out_fill) >= need_w);
            pfav = (owning && xfer_done && er && ew) ? 1 - m_sel : m_ptr;
            if (er && !ew) choice = 0;
            else if (ew && !er) choice = 1;
            else if (rd_pri && !wr_pri) choice = 0;
            else if (wr_pri && !rd_pri) choice = 1;
            else choice = pfav;
            keep = (m_sel == 1) ? ew : er;
            if (m_st == 0) begin
                if (er || ew) begin m_st = 1; m_sel = choice; end
            end else if (m_st == 1) begin
                if (!(er || ew)) m_st = 0;
                else begin
                    if (bus_gnt) m_st = 2;
                    m_sel = choice;
                end
            end else begin
                if (!(er || ew)) m_st = 0;
                else if (xfer_done || !keep) m_sel = choice;
            end
            m_ptr = pfav;
        end
    end

    function automatic logic [7:0] exp_stat();
        logic [7:0] s;
        int vac;
        vac  = DEPTH - int'(in_fill);
        s[0] = (rd_count == 0);
        s[1] = (wr_count == 0);
        s[2] = (in_fill == 0);
        s[3] = (int'(in_fill) == DEPTH);
        s[4] = (vac >= 4);
        s[5] = (out_fill == 0);
        s[6] = (int'(out_fill) == DEPTH);
        s[7] = (int'(out_fill) >= 4);
        return s;
    endfunction

    task automatic compare();
        logic e_req;
        logic e_sel;
        logic [7:0] e_st;
        e_req = (m_st != 0);
        e_sel = (m_sel == 1);
        e_st  = exp_stat();
        n_cmp += 3;
        if (bus_req !== e_req) begin
            n_bad++;
            $display("FAIL %s bus_req got %b exp %b at %0t", tag, bus_req, e_req, $time);
        end
        if (sel_wr !== e_sel) begin
            n_bad++;
            $display("FAIL %s sel_wr got %b exp %b at %0t", tag, sel_wr, e_sel, $time);
        end
        if (stat !== e_st) begin
            n_bad++;
            $display("FAIL R11 stat got %b exp %b at %0t", stat, e_st, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic expect_req(input string t, input logic want);
        n_cmp++;
        if (bus_req !== want) begin
            n_bad++;
            $display("FAIL %s scenario bus_req got %b exp %b", t, bus_req, want);
        end
    endtask

    task automatic done_pulse();
        xfer_done = 1; tick(1); xfer_done = 0; tick(1);
    endtask

    task automatic quiet();
        rd_en = 0; wr_en = 0; bus_gnt = 0; xfer_done = 0; tick(2);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tag = "R1"; tick(3);
        expect_req("R1", 1'b0);
        rst_n = 1; tick(2);

        tag = "R2";
        rd_count = 5; wr_count = 5; out_fill = 8; tick(3);
        expect_req("R2", 1'b0);
        rd_en = 1; wr_en = 1; rd_count = 0; wr_count = 0; tick(3);
        expect_req("R2", 1'b0);
        quiet();

        tag = "R3";
        rd_en = 1; rd_count = 10; rd_thr4 = 1; in_fill = 5; tick(3);
        expect_req("R3", 1'b0);
        in_fill = 4; tick(2);
        expect_req("R3", 1'b1);
        tag = "R9"; rd_en = 0; tick(2);
        expect_req("R9", 1'b0);
        tag = "R3"; rd_thr4 = 0; in_fill = 7; rd_en = 1; tick(2);
        expect_req("R3", 1'b1);
        quiet();

        tag = "R4";
        in_fill = 0; wr_en = 1; wr_count = 6; wr_thr4 = 1; out_fill = 3; tick(3);
        expect_req("R4", 1'b0);
        out_fill = 4; tick(2);
        expect_req("R4", 1'b1);

        tag = "R5";
        bus_gnt = 1; tick(2); bus_gnt = 0;
        out_fill = 1; tick(3);
        expect_req("R5", 1'b1);
        rd_en = 1; rd_thr4 = 1; rd_count = 4; in_fill = 7; tick(2);
        tag = "R10"; wr_en = 0; tick(3);
        expect_req("R10", 1'b1);
        tag = "R9"; rd_count = 0; tick(2);
        expect_req("R9", 1'b0);
        quiet();

        tag = "R6";
        rd_thr4 = 0; wr_thr4 = 0; in_fill = 0; out_fill = 8;
        rd_count = 20; wr_count = 20; rd_pri = 1; wr_pri = 0;
        rd_en = 1; wr_en = 1; tick(3);
        bus_gnt = 1; tick(2); bus_gnt = 0;
        done_pulse(); done_pulse();
        quiet();

        tag = "R7";
        rd_pri = 0; wr_pri = 1; rd_en = 1; wr_en = 1; tick(3);
        bus_gnt = 1; tick(2); bus_gnt = 0;
        done_pulse(); done_pulse();
        quiet();

        tag = "R8";
        rd_pri = 1; wr_pri = 1; rd_en = 1; wr_en = 1; tick(2);
        bus_gnt = 1; tick(2); bus_gnt = 0;
        for (int k = 0; k < 4; k++) done_pulse();
        wr_en = 0; done_pulse(); done_pulse();
        wr_en = 1; done_pulse();
        quiet();
        rd_pri = 0; wr_pri = 0; rd_en = 1; wr_en = 1; tick(2);
        bus_gnt = 1; tick(1); bus_gnt = 0;
        for (int k = 0; k < 3; k++) done_pulse();
        quiet();

        tag = "R10";
        rd_en = 1; wr_en = 1; tick(2);
        tick(4);
        expect_req("R10", 1'b1);
        bus_gnt = 1; tick(1); bus_gnt = 0;
        rd_en = 0; tick(2); rd_en = 1; wr_en = 0; tick(2);
        quiet();

        tag = "R11";
        for (int f = 0; f <= DEPTH; f++) begin
            in_fill = FILL_W'(f); out_fill = FILL_W'(DEPTH - f);
            rd_count = (f % 2 == 0) ? '0 : 16'd3;
            wr_count = (f % 3 == 0) ? '0 : 16'd2;
            tick(1);
        end
        quiet();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule